// File: doc/BRIEF.md
# In-Order Completion Buffer

This block tracks every in-flight instruction from dispatch to retirement in a circular table of sixteen entries. The dispatch stage offers a group of up to four instructions each cycle. The group is accepted whole or not at all, and each instruction receives a consecutive slot tag. Execution units report completion against those tags through several independent finish ports. Branch resolution arrives on its own port and reports either a confirmed prediction or a mispredict. A mispredict cuts the table back to the entry just after the branch in a single cycle.

Each cycle the oldest entries leave in program order. At most four leave per cycle. The count is cut further when the leaving instructions need more architected-register write ports than are available that cycle. A branch that is still unresolved cannot leave. Because retirement is strictly in order, this also holds back every speculative entry behind it, even one that has finished. An entry that finished with an exception always leaves on its own and raises an exception indication, which keeps the architected state precise.

Top module: `cmpl_buf`

## Requirements
- R1: After reset the table is empty: `used` is 0, `full` is 0, `disp_tag` is 0 and `ret_cnt` is 0.
- R2: A dispatch group of `disp_cnt` instructions is accepted (`disp_ok` high) only when `disp_cnt` does not exceed the free entries at the start of the cycle. The whole group is taken or none of it. Its lanes receive tags `disp_tag`, `disp_tag`+1, and so on, modulo 16.
- R3: `full` is high when 16 entries are in flight, and any non-empty group is then refused.
- R4: Retirement takes finished entries from the head in order, at most 4 per cycle. An unfinished entry stops every younger one. `ret_tag` names the oldest retiring entry and advances by `ret_cnt`.
- R5: Walking from the head, the running total of retiring entries whose lane bit in `disp_wb` was 1 never exceeds `wport_avail`. Retirement stops at the first entry that would exceed it.
- R6: A branch entry (lane bit in `disp_br` was 1) retires only after `br_vld` with `br_miss`=0 names its tag. Entries behind it do not retire before then, even if they have finished.
- R7: A group is refused when the unresolved branches in flight plus the branches in the group would exceed 4.
- R8: `br_vld` with `br_miss`=1 resolves the named branch and discards all younger entries at the next edge. `disp_tag` then equals the branch tag plus 1. Dispatch is refused in that cycle.
- R9: An entry whose finish report carried `fin_exc`=1 retires only as the head, alone (`ret_cnt`=1), with `exc_out` high and `exc_tag` equal to its tag. An older finished entry ahead of it retires in an earlier cycle without it.
- R10: When a mispredict and a retirement fall in the same cycle, `used` becomes (branch tag − head + 1) − `ret_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_cnt | input | 3 | Number of instructions in the offered group, lanes 0 upward |
| disp_br | input | 4 | Per lane: instruction is a predicted branch |
| disp_wb | input | 4 | Per lane: instruction needs an architected write port at retirement |
| disp_ok | output | 1 | Group accepted this cycle |
| disp_tag | output | 4 | Tag given to lane 0 of the group |
| fin_vld | input | 4 | Per finish port: report valid |
| fin_tag | input | 16 | Per finish port: 4-bit tag, port k in bits 4k+3:4k |
| fin_exc | input | 4 | Per finish port: instruction raised an exception |
| br_vld | input | 1 | Branch resolution valid |
| br_tag | input | 4 | Tag of the resolved branch |
| br_miss | input | 1 | Branch was mispredicted |
| wport_avail | input | 3 | Architected write ports available this cycle |
| ret_cnt | output | 3 | Entries retiring at this edge |
| ret_tag | output | 4 | Tag of the oldest entry (head) |
| exc_out | output | 1 | The retiring entry carries an exception |
| exc_tag | output | 4 | Tag of the excepting entry |
| full | output | 1 | All 16 entries in flight |
| used | output | 5 | Entries in flight |

## Verification
A mispredict can arrive in the same cycle that older entries leave from the head. The tail is then cut back while the head moves forward, and the occupancy must reflect both. The bench finishes the two oldest entries and then, in the cycle where they retire, reports a mispredict on a younger branch. The resulting occupancy, the next dispatch tag and the head tag are compared against the values computed from R10.

// File: rtl/cmpl_buf_pkg.sv
package cmpl_buf_pkg;

   typedef struct packed {
      logic fin;   // reported done
      logic exc;   // finished with exception
      logic br;    // predicted branch
      logic res;   // branch resolved
      logic wb;    // needs architected write port
   } cb_ent_t;

endpackage

// File: rtl/cbuf_admit.sv
module cbuf_admit #(
   parameter int DEPTH  = 16,
   parameter int DISP_W = 4,
   parameter int MAX_BR = 4,
   localparam int CNTW  = $clog2(DEPTH + 1),
   localparam int DCW   = $clog2(DISP_W + 1)
) (
   input  logic [DCW-1:0]    req_cnt,
   input  logic [DISP_W-1:0] req_br,
   input  logic [CNTW-1:0]   used,
   input  logic [CNTW-1:0]   unres,
   input  logic              flush,
   output logic              ok,
   output logic [DCW-1:0]    take
);

   int br_in;

   always_comb begin
      br_in = 0;
      for (int i = 0; i < DISP_W; i++) begin
         if (i < int'(req_cnt) && req_br[i]) br_in = br_in + 1;
      end
      ok = !flush
           && (int'(req_cnt) <= DISP_W)
           && (int'(req_cnt) <= DEPTH - int'(used))
           && (int'(unres) + br_in <= MAX_BR);
      take = ok ? req_cnt : '0;
   end

endmodule

// File: rtl/cbuf_retire_sel.sv
module cbuf_retire_sel #(
   parameter int RET_W = 4,
   localparam int RCW  = $clog2(RET_W + 1)
) (
   input  logic [RET_W-1:0] live,
   input  logic [RET_W-1:0] rdy,
   input  logic [RET_W-1:0] wb,
   input  logic [RET_W-1:0] exc,
   input  logic [RCW-1:0]   avail,
   output logic [RCW-1:0]   n,
   output logic             exc_hit
);

   int   k;
   int   p;
   logic stop;

   always_comb begin
      k       = 0;
      p       = 0;
      stop    = 1'b0;
      exc_hit = 1'b0;
      for (int i = 0; i < RET_W; i++) begin
         if (!stop) begin
            if (live[i] && rdy[i]
                && (p + int'(wb[i]) <= int'(avail))
                && (!exc[i] || i == 0)) begin
               k = k + 1;
               p = p + int'(wb[i]);
               if (exc[i]) begin
                  exc_hit = 1'b1;
                  stop    = 1'b1;
               end
            end else begin
               stop = 1'b1;
            end
         end
      end
      n = RCW'(k);
   end

endmodule

// File: rtl/cmpl_buf.sv
module cmpl_buf #(
   parameter int DEPTH  = 16,
   parameter int DISP_W = 4,
   parameter int RET_W  = 4,
   parameter int FIN_N  = 4,
   parameter int MAX_BR = 4,
   localparam int IDXW  = $clog2(DEPTH),
   localparam int CNTW  = $clog2(DEPTH + 1),
   localparam int DCW   = $clog2(DISP_W + 1),
   localparam int RCW   = $clog2(RET_W + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [DCW-1:0]        disp_cnt,
   input  logic [DISP_W-1:0]     disp_br,
   input  logic [DISP_W-1:0]     disp_wb,
   output logic                  disp_ok,
   output logic [IDXW-1:0]       disp_tag,
   input  logic [FIN_N-1:0]      fin_vld,
   input  logic [FIN_N*IDXW-1:0] fin_tag,
   input  logic [FIN_N-1:0]      fin_exc,
   input  logic                  br_vld,
   input  logic [IDXW-1:0]       br_tag,
   input  logic                  br_miss,
   input  logic [RCW-1:0]        wport_avail,
   output logic [RCW-1:0]        ret_cnt,
   output logic [IDXW-1:0]       ret_tag,
   output logic                  exc_out,
   output logic [IDXW-1:0]       exc_tag,
   output logic                  full,
   output logic [CNTW-1:0]       used
);
   import cmpl_buf_pkg::*;

   // elaboration-time parameter checks
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("cmpl_buf: DEPTH must be a power of two >= 2");
   end
   if (DISP_W > DEPTH || RET_W > DEPTH) begin : g_bad_width
      $error("cmpl_buf: group widths must not exceed DEPTH");
   end
   if (FIN_N < 1 || MAX_BR < 1) begin : g_bad_ports
      $error("cmpl_buf: FIN_N and MAX_BR must be at least 1");
   end

   cb_ent_t          ent [DEPTH];
   logic [IDXW-1:0]  head;
   logic [CNTW-1:0]  used_q;
   logic [IDXW-1:0]  tail;
   logic [CNTW-1:0]  unres;
   logic             flush;
   logic [DCW-1:0]   take;
   logic [RCW-1:0]   ret_n;
   logic             exc_hit;
   logic [CNTW-1:0]  cut_len;

   logic [RET_W-1:0] w_live, w_rdy, w_wb, w_exc;

   assign tail    = head + IDXW'(used_q);
   assign flush   = br_vld && br_miss;
   assign cut_len = CNTW'(IDXW'(br_tag - head)) + CNTW'(1);

   // view of the oldest RET_W entries, head first
   for (genvar gi = 0; gi < RET_W; gi++) begin : g_win
      logic [IDXW-1:0] idx;
      assign idx       = head + IDXW'(gi);
      assign w_live[gi] = (gi < int'(used_q));
      assign w_rdy[gi]  = ent[idx].fin && (!ent[idx].br || ent[idx].res);
      assign w_wb[gi]   = ent[idx].wb;
      assign w_exc[gi]  = ent[idx].exc;
   end

   // unresolved branches among live entries
   always_comb begin
      unres = '0;
      for (int j = 0; j < DEPTH; j++) begin
         if (j < int'(used_q)
             && ent[head + IDXW'(j)].br && !ent[head + IDXW'(j)].res)
            unres = unres + CNTW'(1);
      end
   end

   cbuf_admit #(
      .DEPTH  (DEPTH),
      .DISP_W (DISP_W),
      .MAX_BR (MAX_BR)
   ) u_admit (
      .req_cnt (disp_cnt),
      .req_br  (disp_br),
      .used    (used_q),
      .unres   (unres),
      .flush   (flush),
      .ok      (disp_ok),
      .take    (take)
   );

   cbuf_retire_sel #(
      .RET_W (RET_W)
   ) u_ret (
      .live    (w_live),
      .rdy     (w_rdy),
      .wb      (w_wb),
      .exc     (w_exc),
      .avail   (wport_avail),
      .n       (ret_n),
      .exc_hit (exc_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head   <= '0;
         used_q <= '0;
         for (int e = 0; e < DEPTH; e++) ent[e] <= '0;
      end else begin
         head <= head + IDXW'(ret_n);
         if (flush)
            used_q <= cut_len - CNTW'(ret_n);
         else
            used_q <= used_q + CNTW'(take) - CNTW'(ret_n);

         for (int l = 0; l < DISP_W; l++) begin
            if (l < int'(take)) begin
               ent[tail + IDXW'(l)] <= '{fin: 1'b0, exc: 1'b0,
                                         br: disp_br[l], res: 1'b0,
                                         wb: disp_wb[l]};
            end
         end

         for (int f = 0; f < FIN_N; f++) begin
            if (fin_vld[f]) begin
               ent[fin_tag[f*IDXW +: IDXW]].fin <= 1'b1;
               if (fin_exc[f]) ent[fin_tag[f*IDXW +: IDXW]].exc <= 1'b1;
            end
         end

         if (br_vld) begin
            ent[br_tag].res <= 1'b1;
            ent[br_tag].fin <= 1'b1;
         end
      end
   end

   assign disp_tag = tail;
   assign ret_cnt  = ret_n;
   assign ret_tag  = head;
   assign exc_out  = exc_hit;
   assign exc_tag  = head;
   assign full     = (used_q == CNTW'(DEPTH));
   assign used     = used_q;

endmodule

// File: rtl/cmpl_buf_chk.sv
module cmpl_buf_chk #(
   parameter int DEPTH  = 16,
   parameter int DISP_W = 4,
   parameter int RET_W  = 4,
   localparam int IDXW  = $clog2(DEPTH),
   localparam int CNTW  = $clog2(DEPTH + 1),
   localparam int DCW   = $clog2(DISP_W + 1),
   localparam int RCW   = $clog2(RET_W + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic [DCW-1:0]  disp_cnt,
   input logic            disp_ok,
   input logic [IDXW-1:0] disp_tag,
   input logic            br_vld,
   input logic            br_miss,
   input logic [IDXW-1:0] br_tag,
   input logic [RCW-1:0]  ret_cnt,
   input logic [IDXW-1:0] ret_tag,
   input logic            exc_out,
   input logic            full,
   input logic [CNTW-1:0] used
);

   // R3
   used_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(used) <= DEPTH);

   // R3
   full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && disp_cnt != '0) |-> !disp_ok);

   // R4
   ret_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ret_cnt) <= int'(used) && int'(ret_cnt) <= RET_W);

   // R4
   head_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ret_tag == $past(ret_tag) + IDXW'($past(ret_cnt)));

   // R9
   exc_solo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_out |-> ret_cnt == RCW'(1));

   // R8
   flush_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_vld && br_miss) |=> disp_tag == $past(br_tag) + IDXW'(1));

   // R8
   flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_vld && br_miss) |-> !disp_ok);

   // R2
   grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_ok && !(br_vld && br_miss)) |=>
         used == $past(used) + CNTW'($past(disp_cnt)) - CNTW'($past(ret_cnt)));

endmodule

bind cmpl_buf cmpl_buf_chk #(
   .DEPTH  (DEPTH),
   .DISP_W (DISP_W),
   .RET_W  (RET_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .disp_cnt (disp_cnt),
   .disp_ok  (disp_ok),
   .disp_tag (disp_tag),
   .br_vld   (br_vld),
   .br_miss  (br_miss),
   .br_tag   (br_tag),
   .ret_cnt  (ret_cnt),
   .ret_tag  (ret_tag),
   .exc_out  (exc_out),
   .full     (full),
   .used     (used)
);

// File: tb/cmpl_buf_tb.sv
`timescale 1ns/1ps
module cmpl_buf_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  disp_cnt = '0;
   logic [3:0]  disp_br = '0, disp_wb = '0;
   logic        disp_ok;
   logic [3:0]  disp_tag;
   logic [3:0]  fin_vld = '0, fin_exc = '0;
   logic [15:0] fin_tag = '0;
   logic        br_vld = 1'b0, br_miss = 1'b0;
   logic [3:0]  br_tag = '0;
   logic [2:0]  wport_avail = 3'd4;
   logic [2:0]  ret_cnt;
   logic [3:0]  ret_tag, exc_tag;
   logic        exc_out, full;
   logic [4:0]  used;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   cmpl_buf u_dut (
      .clk(clk), .rst_n(rst_n),
      .disp_cnt(disp_cnt), .disp_br(disp_br), .disp_wb(disp_wb),
      .disp_ok(disp_ok), .disp_tag(disp_tag),
      .fin_vld(fin_vld), .fin_tag(fin_tag), .fin_exc(fin_exc),
      .br_vld(br_vld), .br_tag(br_tag), .br_miss(br_miss),
      .wport_avail(wport_avail),
      .ret_cnt(ret_cnt), .ret_tag(ret_tag),
      .exc_out(exc_out), .exc_tag(exc_tag),
      .full(full), .used(used)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk); #1;
      disp_cnt = '0; disp_br = '0; disp_wb = '0;
      fin_vld = '0; fin_exc = '0; br_vld = 1'b0; br_miss = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; wport_avail = 3'd4;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic disp(input int n, input logic [3:0] br, input logic [3:0] wb,
                       input int exp_ok, input string req);
      disp_cnt = 3'(n); disp_br = br; disp_wb = wb;
      #1 chk(req, int'(disp_ok), exp_ok);
      cyc();
   endtask

   task automatic fin(input logic [3:0] m, input int t0, input int t1,
                      input int t2, input int t3, input logic [3:0] ex);
      fin_vld = m; fin_exc = ex;
      fin_tag = {4'(t3), 4'(t2), 4'(t1), 4'(t0)};
      cyc();
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 used", int'(used), 0);
      chk("R1 full", int'(full), 0);
      chk("R1 disp_tag", int'(disp_tag), 0);
      chk("R1 ret_cnt", int'(ret_cnt), 0);
   endtask

   task automatic t_fill_order();
      do_reset();
      for (int g = 0; g < 4; g++) begin
         chk("R2 group tag", int'(disp_tag), g * 4);
         disp(4, 4'b0, 4'b0, 1, "R2 accept");
      end
      chk("R3 used full", int'(used), 16);
      chk("R3 full", int'(full), 1);
      disp(1, 4'b0, 4'b0, 0, "R3 refuse when full");
      fin(4'b0011, 1, 2, 0, 0, 4'b0);
      chk("R4 head unfinished blocks", int'(ret_cnt), 0);
      fin(4'b0001, 0, 0, 0, 0, 4'b0);
      chk("R4 in-order run", int'(ret_cnt), 3);
      chk("R4 ret_tag", int'(ret_tag), 0);
      disp(1, 4'b0, 4'b0, 0, "R3 refuse, retire same edge");
      chk("R4 used after retire", int'(used), 13);
      disp(4, 4'b0, 4'b0, 0, "R2 all-or-nothing refuse");
      chk("R2 used unchanged", int'(used), 13);
      chk("R2 tail wrap", int'(disp_tag), 0);
      disp(3, 4'b0, 4'b0, 1, "R2 exact fit");
      chk("R2 used refilled", int'(used), 16);
      fin(4'b0001, 7, 0, 0, 0, 4'b0);
      fin(4'b1111, 3, 4, 5, 6, 4'b0);
      chk("R4 cap four", int'(ret_cnt), 4);
      chk("R4 ret_tag head", int'(ret_tag), 3);
   endtask

   task automatic t_ports();
      do_reset();
      disp(4, 4'b0, 4'b0101, 1, "R5 setup");
      fin(4'b1111, 0, 1, 2, 3, 4'b0);
      wport_avail = 3'd1;
      #1 chk("R5 one port", int'(ret_cnt), 2);
      cyc();
      wport_avail = 3'd0;
      #1 chk("R5 no port", int'(ret_cnt), 0);
      wport_avail = 3'd2;
      #1 chk("R5 two ports", int'(ret_cnt), 2);
      cyc();
   endtask

   task automatic t_branch_hold();
      do_reset();
      disp(4, 4'b0010, 4'b0, 1, "R6 setup");
      fin(4'b0111, 0, 2, 3, 0, 4'b0);
      chk("R6 stop at branch", int'(ret_cnt), 1);
      cyc();
      chk("R6 held behind branch", int'(ret_cnt), 0);
      br_vld = 1'b1; br_tag = 4'd1; br_miss = 1'b0;
      #1 chk("R6 held during resolve", int'(ret_cnt), 0);
      cyc();
      chk("R6 released", int'(ret_cnt), 3);
      chk("R6 ret_tag", int'(ret_tag), 1);
   endtask

   task automatic t_branch_limit();
      do_reset();
      disp(4, 4'b1111, 4'b0, 1, "R7 four branches");
      disp(1, 4'b0001, 4'b0, 0, "R7 fifth branch");
      disp(1, 4'b0000, 4'b0, 1, "R7 plain allowed");
      br_vld = 1'b1; br_tag = 4'd0; br_miss = 1'b0;
      cyc();
      disp(1, 4'b0001, 4'b0, 1, "R7 after resolve");
   endtask

   task automatic t_flush();
      do_reset();
      disp(4, 4'b0100, 4'b0, 1, "R8 setup a");
      disp(4, 4'b0, 4'b0, 1, "R8 setup b");
      br_vld = 1'b1; br_tag = 4'd2; br_miss = 1'b1;
      disp_cnt = 3'd2;
      #1 chk("R8 dispatch blocked", int'(disp_ok), 0);
      cyc();
      chk("R8 tail", int'(disp_tag), 3);
      chk("R8 used", int'(used), 3);
      fin(4'b0011, 0, 1, 0, 0, 4'b0);
      chk("R8 survivors retire", int'(ret_cnt), 3);
   endtask

   task automatic t_exc();
      do_reset();
      disp(4, 4'b0, 4'b0, 1, "R9 setup");
      fin(4'b1111, 0, 1, 2, 3, 4'b0010);
      chk("R9 stop before exc", int'(ret_cnt), 1);
      chk("R9 no exc yet", int'(exc_out), 0);
      cyc();
      chk("R9 alone", int'(ret_cnt), 1);
      chk("R9 exc_out", int'(exc_out), 1);
      chk("R9 exc_tag", int'(exc_tag), 1);
      cyc();
      chk("R9 rest", int'(ret_cnt), 2);
      chk("R9 exc clear", int'(exc_out), 0);
   endtask

   task automatic t_both();
      do_reset();
      disp(4, 4'b1000, 4'b0, 1, "R10 setup");
      fin(4'b0011, 0, 1, 0, 0, 4'b0);
      br_vld = 1'b1; br_tag = 4'd3; br_miss = 1'b1;
      #1 chk("R10 retire with flush", int'(ret_cnt), 2);
      cyc();
      chk("R10 used", int'(used), 2);
      chk("R10 tail", int'(disp_tag), 4);
      chk("R10 head", int'(ret_tag), 2);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      t_reset();
      t_fill_order();
      t_ports();
      t_branch_hold();
      t_branch_limit();
      t_flush();
      t_exc();
      t_both();
      finish_run();
   end

endmodule